// File: doc/BRIEF.md
# Accelerator Control Register Block

This block is the memory-mapped control front end for a single compute core. A host talks to it over an AXI4-Lite slave port. The core talks to it through a start/done/idle/ready handshake. The host writes two 32-bit pointer arguments and one 32-bit instruction word, which the block drives straight to the core. It also launches the core and later collects a 32-bit status word and a 64-bit result, each of which carries a sticky valid flag.

Several registers have access side effects:

- The launch bit drops when the core accepts the job. An auto-relaunch bit keeps it asserted.
- The completion and valid flags clear when the host reads them.
- The interrupt-pending bits flip when a 1 is written to them.

A level interrupt combines the pending bits, the per-channel enables and a master enable.

Top module: `acc_ctrl_top`

## Requirements
- R1: After reset every stored register is zero, `core_start` and `irq` are low, and reading offset 0x00 with `core_idle` high and `core_ready` low returns 0x00000004.
- R2: Offsets 0x10 (input pointer), 0x18 (output pointer) and 0x34 (instruction) read back what was written, byte lane n being updated only when strobe bit n is set; their values appear on `arg_in`, `arg_out` and `arg_inst`.
- R3: Reads of offsets 0x14, 0x1C, 0x38 return zero, and writes to them change no register.
- R4: In the control word at 0x00, writing a 1 to bit 0 sets the launch bit and writing 0 leaves it unchanged. Bit 7 is the auto-relaunch bit, stored from every control write. While set, the launch bit drives `core_start`. It clears on the cycle `core_ready` is high, unless auto-relaunch is set, in which case it stays set.
- R5: Control bit 1 (done) sets on a `core_done` pulse and stays set until a read of 0x00 has returned it, after which it reads 0.
- R6: Control bit 2 shows `core_idle` and bit 3 shows `core_ready` as they are when the read is accepted.
- R7: Offset 0x04 bit 0 is the master interrupt enable and offset 0x08 bits 1:0 are the channel enables (bit 0 done, bit 1 ready); all their other bits read zero.
- R8: Offset 0x0C holds the pending bits (bit 0 done, bit 1 ready). A pending bit sets on its event (`core_done`, or `core_ready` while launching) only if its channel is enabled, and writing 1 to a bit inverts it.
- R9: `irq` is high exactly when the master enable is set and some pending bit has its channel enable set.
- R10: A `core_status_vld` pulse captures `core_status` into offset 0x20 and sets bit 0 of 0x24. That flag clears once a read of 0x24 has returned it.
- R11: A `core_result_vld` pulse captures the 64-bit `core_result`. The low word reads at 0x28 and the high word at 0x2C. Bit 0 of 0x30 is set by the pulse and clears once a read of 0x30 has returned it.
- R12: Write address and write data are accepted in either order or together. Every response is OKAY (00), and `s_bvalid` and `s_rvalid`, with unchanged read data, hold until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | Launch request to the core |
| core_done | input | 1 | One-cycle completion pulse |
| core_idle | input | 1 | Core is idle |
| core_ready | input | 1 | Core accepts a launch |
| arg_in | output | 32 | Input pointer argument |
| arg_out | output | 32 | Output pointer argument |
| arg_inst | output | 32 | Instruction argument |
| core_status | input | 32 | Status word from the core |
| core_status_vld | input | 1 | Status capture pulse |
| core_result | input | 64 | Result from the core |
| core_result_vld | input | 1 | Result capture pulse |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties watch these rules on every cycle:

- the launch bit clearing or holding on a core acceptance, depending on auto-relaunch;
- the done, status-valid and result-valid flags setting on their pulses and clearing after a read;
- enabled events always leaving a pending bit;
- the interrupt staying low with nothing pending;
- both bus responses holding until taken.

Byte-strobe merging, reserved offsets reading zero, the inversion of pending bits on write, the address/data arrival order, and the exact word seen by the host around a clear-on-read are shown only by the bench's scenarios.

// File: rtl/acc_ctrl_pkg.sv
// Shared constants and helpers for the accelerator control register block.
// Word indices are byte offsets divided by four.
package acc_ctrl_pkg;
    localparam int REG_W  = 32;
    localparam int STRB_W = REG_W / 8;

    localparam int W_CTRL  = 0;   // 0x00
    localparam int W_GIE   = 1;   // 0x04
    localparam int W_IER   = 2;   // 0x08
    localparam int W_ISR   = 3;   // 0x0C
    localparam int W_ARGI  = 4;   // 0x10
    localparam int W_ARGO  = 6;   // 0x18
    localparam int W_STAT  = 8;   // 0x20
    localparam int W_STATV = 9;   // 0x24
    localparam int W_RESL  = 10;  // 0x28
    localparam int W_RESH  = 11;  // 0x2C
    localparam int W_RESV  = 12;  // 0x30
    localparam int W_INST  = 13;  // 0x34

    localparam int N_ARGS = 3;

    // Replace the byte lanes of old_v selected by strb with those of new_v.
    function automatic logic [REG_W-1:0] strb_merge(input logic [REG_W-1:0] old_v,
                                                    input logic [REG_W-1:0] new_v,
                                                    input logic [STRB_W-1:0] strb);
        logic [REG_W-1:0] r;
        r = old_v;
        for (int b = 0; b < STRB_W; b++)
            if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/acc_axil_wr.sv
// AXI4-Lite write channel front end.
// Holds write address and write data separately, so they may arrive in either
// order. Issues a one-cycle register write once both are held and no response
// is outstanding, then raises an OKAY response until it is accepted.
module acc_axil_wr
    import acc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [REG_W-1:0]  wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data,
    output logic [STRB_W-1:0] wr_strb
);
    logic aw_full, w_full, bvalid_q;

    assign awready = !aw_full;
    assign wready  = !w_full;
    assign wr_en   = aw_full && w_full && !bvalid_q;
    assign bvalid  = bvalid_q;
    assign bresp   = 2'b00;

    // Capture address and data halves, then retire them into a response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_full  <= 1'b0;
            w_full   <= 1'b0;
            bvalid_q <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_strb  <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_full <= 1'b1;
                wr_addr <= awaddr;
            end
            if (wvalid && wready) begin
                w_full  <= 1'b1;
                wr_data <= wdata;
                wr_strb <= wstrb;
            end
            if (wr_en) begin
                aw_full  <= 1'b0;
                w_full   <= 1'b0;
                bvalid_q <= 1'b1;
            end else if (bvalid_q && bready) begin
                bvalid_q <= 1'b0;
            end
        end
    end

    // R12
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
endmodule

// File: rtl/acc_axil_rd.sv
// AXI4-Lite read channel front end.
// Accepts one read at a time. On acceptance it pulses rd_en, so that the
// register file can apply its clear-on-read effects, and captures the word
// presented for that address. The data then holds until the host takes it.
module acc_axil_rd
    import acc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [REG_W-1:0]  rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  rd_word
);
    logic rvalid_q;

    assign arready = !rvalid_q;
    assign rd_en   = arvalid && arready;
    assign rd_addr = araddr;
    assign rvalid  = rvalid_q;
    assign rresp   = 2'b00;

    // Latch the read word on acceptance and hold it until it is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata    <= '0;
        end else if (rd_en) begin
            rvalid_q <= 1'b1;
            rdata    <= rd_word;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

    // R12
    rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

// File: rtl/acc_ctrl_regs.sv
// Register file of the accelerator control block.
// Decodes one-cycle write and read strobes from the bus front ends and applies
// the launch, clear-on-read and invert-on-write side effects. Captures the
// core's status and result, and forms the interrupt. Assumes one-cycle
// core_done and valid pulses, and byte offsets below 2**ADDR_W.
module acc_ctrl_regs
    import acc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_word,
    output logic              core_start,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic [REG_W-1:0]  arg_in,
    output logic [REG_W-1:0]  arg_out,
    output logic [REG_W-1:0]  arg_inst,
    input  logic [REG_W-1:0]  core_status,
    input  logic              core_status_vld,
    input  logic [2*REG_W-1:0] core_result,
    input  logic              core_result_vld,
    output logic              irq
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int ARG_IDX [N_ARGS] = '{W_ARGI, W_ARGO, W_INST};

    logic [WORD_W-1:0] w_wd, r_wd;
    logic start_q, auto_q, done_q, gie_q;
    logic [1:0] ier_q, isr_q, isr_tog, isr_evt;
    logic stat_vld_q, res_vld_q;
    logic [REG_W-1:0] stat_q;
    logic [2*REG_W-1:0] res_q;
    logic [REG_W-1:0] arg_q [N_ARGS];
    logic wr_ctrl, ctrl_set, launch_ack;

    assign w_wd       = wr_addr[ADDR_W-1:2];
    assign r_wd       = rd_addr[ADDR_W-1:2];
    assign wr_ctrl    = wr_en && (w_wd == WORD_W'(W_CTRL)) && wr_strb[0];
    assign ctrl_set   = wr_ctrl && wr_data[0];
    assign launch_ack = start_q && core_ready;
    assign core_start = start_q;

    // Launch bit and auto-relaunch bit; a host set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            auto_q  <= 1'b0;
        end else begin
            if (launch_ack && !auto_q) start_q <= 1'b0;
            if (ctrl_set)              start_q <= 1'b1;
            if (wr_ctrl)               auto_q  <= wr_data[7];
        end
    end

    // Sticky completion flag, cleared by a read of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else begin
            if (rd_en && r_wd == WORD_W'(W_CTRL)) done_q <= 1'b0;
            if (core_done)                        done_q <= 1'b1;
        end
    end

    assign isr_tog = (wr_en && w_wd == WORD_W'(W_ISR) && wr_strb[0]) ? wr_data[1:0] : 2'b00;
    assign isr_evt = {launch_ack & ier_q[1], core_done & ier_q[0]};

    // Interrupt enables and pending bits (invert on write, set on enabled event).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            ier_q <= 2'b00;
            isr_q <= 2'b00;
        end else begin
            if (wr_en && w_wd == WORD_W'(W_GIE) && wr_strb[0]) gie_q <= wr_data[0];
            if (wr_en && w_wd == WORD_W'(W_IER) && wr_strb[0]) ier_q <= wr_data[1:0];
            isr_q <= (isr_q ^ isr_tog) | isr_evt;
        end
    end

    // One byte-strobed argument register per argument word.
    for (genvar gi = 0; gi < N_ARGS; gi++) begin : g_arg
        always_ff @(posedge clk) begin
            if (!rst_n) arg_q[gi] <= '0;
            else if (wr_en && w_wd == WORD_W'(ARG_IDX[gi]))
                arg_q[gi] <= strb_merge(arg_q[gi], wr_data, wr_strb);
        end
    end
    assign arg_in   = arg_q[0];
    assign arg_out  = arg_q[1];
    assign arg_inst = arg_q[2];

    // Capture core status and result with their clear-on-read valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q     <= '0;
            res_q      <= '0;
            stat_vld_q <= 1'b0;
            res_vld_q  <= 1'b0;
        end else begin
            if (rd_en && r_wd == WORD_W'(W_STATV)) stat_vld_q <= 1'b0;
            if (rd_en && r_wd == WORD_W'(W_RESV))  res_vld_q  <= 1'b0;
            if (core_status_vld) begin
                stat_q     <= core_status;
                stat_vld_q <= 1'b1;
            end
            if (core_result_vld) begin
                res_q     <= core_result;
                res_vld_q <= 1'b1;
            end
        end
    end

    // Read multiplexer; unlisted offsets read zero.
    always_comb begin
        rd_word = '0;
        case (r_wd)
            WORD_W'(W_CTRL):  rd_word = {24'd0, auto_q, 3'd0, core_ready, core_idle, done_q, start_q};
            WORD_W'(W_GIE):   rd_word = {31'd0, gie_q};
            WORD_W'(W_IER):   rd_word = {30'd0, ier_q};
            WORD_W'(W_ISR):   rd_word = {30'd0, isr_q};
            WORD_W'(W_ARGI):  rd_word = arg_q[0];
            WORD_W'(W_ARGO):  rd_word = arg_q[1];
            WORD_W'(W_STAT):  rd_word = stat_q;
            WORD_W'(W_STATV): rd_word = {31'd0, stat_vld_q};
            WORD_W'(W_RESL):  rd_word = res_q[REG_W-1:0];
            WORD_W'(W_RESH):  rd_word = res_q[2*REG_W-1:REG_W];
            WORD_W'(W_RESV):  rd_word = {31'd0, res_vld_q};
            WORD_W'(W_INST):  rd_word = arg_q[2];
            default:          rd_word = '0;
        endcase
    end

    // Level interrupt from enabled pending bits.
    assign irq = gie_q && |(ier_q & isr_q);

    // R4
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && core_ready && !auto_q && !ctrl_set) |=> !core_start);
    // R4
    start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && auto_q) |=> core_start);
    // R5
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && r_wd == WORD_W'(W_CTRL) && !core_done) |=> !done_q);
    // R8
    isr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && ier_q[0]) |=> isr_q[0]);
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_q == 2'b00) |-> !irq);
    // R10
    stat_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_status_vld |=> stat_vld_q);
    // R11
    res_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_result_vld |=> res_vld_q);
endmodule

// File: rtl/acc_ctrl_top.sv
// Accelerator control register block: AXI4-Lite slave plus core handshake.
// Joins the write front end, the read front end and the register file.
// Assumes a single clock domain and a 32-bit bus.
module acc_ctrl_top
    import acc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              core_start,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic [31:0]       arg_in,
    output logic [31:0]       arg_out,
    output logic [31:0]       arg_inst,
    input  logic [31:0]       core_status,
    input  logic              core_status_vld,
    input  logic [63:0]       core_result,
    input  logic              core_result_vld,
    output logic              irq
);
    logic              wr_en, rd_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [REG_W-1:0]  wr_data, rd_word;
    logic [STRB_W-1:0] wr_strb;

    acc_axil_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
    );

    acc_axil_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_word(rd_word)
    );

    acc_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_word(rd_word),
        .core_start(core_start), .core_done(core_done),
        .core_idle(core_idle), .core_ready(core_ready),
        .arg_in(arg_in), .arg_out(arg_out), .arg_inst(arg_inst),
        .core_status(core_status), .core_status_vld(core_status_vld),
        .core_result(core_result), .core_result_vld(core_result_vld),
        .irq(irq)
    );
endmodule

// File: tb/tb_acc_ctrl_top.sv
// Self-checking bench: a register vector table, then directed scenarios.
module tb_acc_ctrl_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] s_awaddr = '0, s_araddr = '0;
    logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
    logic [31:0] s_wdata = '0;
    logic [3:0] s_wstrb = '0;
    logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0] s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic core_start, irq;
    logic core_done = 0, core_idle = 1, core_ready = 0;
    logic [31:0] arg_in, arg_out, arg_inst;
    logic [31:0] core_status = '0;
    logic core_status_vld = 0;
    logic [63:0] core_result = '0;
    logic core_result_vld = 0;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    acc_ctrl_top #(.ADDR_W(6)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .core_start(core_start), .core_done(core_done), .core_idle(core_idle),
        .core_ready(core_ready), .arg_in(arg_in), .arg_out(arg_out), .arg_inst(arg_inst),
        .core_status(core_status), .core_status_vld(core_status_vld),
        .core_result(core_result), .core_result_vld(core_result_vld), .irq(irq)
    );

    typedef struct packed {
        logic [5:0]  addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{6'h10, 32'hDEADBEEF, 4'hF, 32'hDEADBEEF},  // R2
        '{6'h10, 32'h00001122, 4'h3, 32'hDEAD1122},  // R2 low lanes
        '{6'h18, 32'hA5A5A5A5, 4'hF, 32'hA5A5A5A5},  // R2
        '{6'h18, 32'hFFFFFFFF, 4'h8, 32'hFFA5A5A5},  // R2 top lane
        '{6'h34, 32'h12345678, 4'hF, 32'h12345678},  // R2
        '{6'h34, 32'h00AB0000, 4'h4, 32'h12AB5678},  // R2 lane 2
        '{6'h14, 32'hFFFFFFFF, 4'hF, 32'h00000000},  // R3
        '{6'h1C, 32'hFFFFFFFF, 4'hF, 32'h00000000},  // R3
        '{6'h38, 32'hFFFFFFFF, 4'hF, 32'h00000000},  // R3
        '{6'h04, 32'hFFFFFFFF, 4'hF, 32'h00000001},  // R7
        '{6'h08, 32'hFFFFFFFF, 4'hF, 32'h00000003},  // R7
        '{6'h08, 32'h00000000, 4'hF, 32'h00000000},  // R7
        '{6'h04, 32'h00000000, 4'hF, 32'h00000000}   // R7
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus write; aw_lag / w_lag delay each channel by that many cycles.
    task automatic axw(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s,
                       input int aw_lag, input int w_lag);
        int t = 0;
        bit aw_done = 0, w_done = 0, aw_hit, w_hit;
        s_awaddr = a; s_wdata = d; s_wstrb = s;
        while (!(aw_done && w_done)) begin
            s_awvalid = !aw_done && (t >= aw_lag);
            s_wvalid  = !w_done && (t >= w_lag);
            #1;
            aw_hit = s_awvalid && s_awready;
            w_hit  = s_wvalid && s_wready;
            @(negedge clk);
            t++;
            if (aw_hit) aw_done = 1;
            if (w_hit)  w_done = 1;
        end
        s_awvalid = 0; s_wvalid = 0;
        s_bready = 1;
        while (!s_bvalid) @(negedge clk);
        check("R12 bresp", {62'd0, s_bresp}, 64'd0);
        @(negedge clk);
        s_bready = 0;
    endtask

    task automatic axr(input logic [5:0] a, output logic [31:0] d);
        s_araddr = a; s_arvalid = 1;
        #1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 0;
        s_rready = 1;
        while (!s_rvalid) @(negedge clk);
        d = s_rdata;
        check("R12 rresp", {62'd0, s_rresp}, 64'd0);
        @(negedge clk);
        s_rready = 0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        axr(a, v);
        check(req, {32'd0, v}, {32'd0, exp});
    endtask

    // which: 0 done, 1 ready, 2 done+ready, 3 status valid, 4 result valid
    task automatic pulse(input int which);
        core_done       = (which == 0 || which == 2);
        core_ready      = (which == 1 || which == 2);
        core_status_vld = (which == 3);
        core_result_vld = (which == 4);
        @(negedge clk);
        core_done = 0; core_ready = 0; core_status_vld = 0; core_result_vld = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 core_start", {63'd0, core_start}, 64'd0);
        check("R1 irq", {63'd0, irq}, 64'd0);
        rd_chk("R1 ctrl", 6'h00, 32'h00000004);
        rd_chk("R1 arg_in", 6'h10, 32'h0);
        rd_chk("R1 isr", 6'h0C, 32'h0);

        // Vector table; the channel order varies with the index (R12).
        for (int i = 0; i < NV; i++) begin
            axw(VEC[i].addr, VEC[i].data, VEC[i].strb, (i % 3 == 1) ? 2 : 0, (i % 3 == 2) ? 3 : 0);
            rd_chk("R2/R3/R7 table", VEC[i].addr, VEC[i].exp);
        end
        check("R2 arg_in port", {32'd0, arg_in}, {32'd0, 32'hDEAD1122});
        check("R2 arg_out port", {32'd0, arg_out}, {32'd0, 32'hFFA5A5A5});
        check("R2 arg_inst port", {32'd0, arg_inst}, {32'd0, 32'h12AB5678});

        // R6 live idle/ready bits
        core_idle = 0; core_ready = 1;
        rd_chk("R6 ctrl live", 6'h00, 32'h00000008);
        core_ready = 0;

        // R4 launch and clear on acceptance
        axw(6'h00, 32'h1, 4'hF, 0, 0);
        check("R4 start set", {63'd0, core_start}, 64'd1);
        rd_chk("R4 ctrl start", 6'h00, 32'h00000001);
        axw(6'h00, 32'h0, 4'hF, 0, 0);
        check("R4 write 0 ignored", {63'd0, core_start}, 64'd1);
        pulse(2);
        check("R4 start cleared", {63'd0, core_start}, 64'd0);
        check("R8 disabled no irq", {63'd0, irq}, 64'd0);
        rd_chk("R5 done seen", 6'h00, 32'h00000002);
        rd_chk("R5 done cleared", 6'h00, 32'h00000000);

        // R4 auto-relaunch
        axw(6'h00, 32'h81, 4'hF, 0, 0);
        pulse(1);
        check("R4 auto keeps start", {63'd0, core_start}, 64'd1);
        rd_chk("R4 ctrl auto", 6'h00, 32'h00000081);
        axw(6'h00, 32'h0, 4'hF, 0, 0);
        check("R4 start after auto off", {63'd0, core_start}, 64'd1);
        pulse(1);
        check("R4 start clears", {63'd0, core_start}, 64'd0);
        rd_chk("R8 no pending while disabled", 6'h0C, 32'h0);

        // R8 / R9 interrupts
        axw(6'h04, 32'h1, 4'hF, 0, 0);
        axw(6'h08, 32'h1, 4'hF, 0, 0);
        check("R9 irq idle", {63'd0, irq}, 64'd0);
        pulse(0);
        check("R9 irq on done", {63'd0, irq}, 64'd1);
        rd_chk("R8 isr done", 6'h0C, 32'h1);
        axw(6'h00, 32'h1, 4'hF, 0, 0);
        pulse(1);
        rd_chk("R8 ready channel masked", 6'h0C, 32'h1);
        axw(6'h0C, 32'h1, 4'hF, 1, 0);
        rd_chk("R8 toggle clears", 6'h0C, 32'h0);
        check("R9 irq cleared", {63'd0, irq}, 64'd0);
        axw(6'h0C, 32'h2, 4'hF, 0, 1);
        rd_chk("R8 toggle sets", 6'h0C, 32'h2);
        check("R9 masked bit", {63'd0, irq}, 64'd0);
        axw(6'h08, 32'h3, 4'hF, 0, 0);
        check("R9 unmasked", {63'd0, irq}, 64'd1);
        axw(6'h04, 32'h0, 4'hF, 0, 0);
        check("R9 master off", {63'd0, irq}, 64'd0);
        axw(6'h0C, 32'h2, 4'hF, 0, 0);
        axw(6'h00, 32'h1, 4'hF, 0, 0);
        pulse(1);
        rd_chk("R8 ready event", 6'h0C, 32'h2);

        // R10 status capture
        core_status = 32'hCAFE0001;
        pulse(3);
        core_status = 32'h55555555;
        rd_chk("R10 status valid", 6'h24, 32'h1);
        rd_chk("R10 status value", 6'h20, 32'hCAFE0001);
        rd_chk("R10 valid cleared", 6'h24, 32'h0);

        // R11 result capture
        core_result = 64'h0123456789ABCDEF;
        pulse(4);
        core_result = '0;
        rd_chk("R11 result valid", 6'h30, 32'h1);
        rd_chk("R11 low word", 6'h28, 32'h89ABCDEF);
        rd_chk("R11 high word", 6'h2C, 32'h01234567);
        rd_chk("R11 valid cleared", 6'h30, 32'h0);

        finish_run();
    end
endmodule